// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Controller

This block keeps two small pending vectors for a cluster of up to four CPUs. One holds inter-processor interrupts (IPIs) and the other holds interval-timer interrupts. Each bit of each vector drives a level interrupt line to its CPU. Software reaches the vectors through four word-wide registers. The first is a combined register whose fields can post IPIs, acknowledge IPIs and acknowledge timer interrupts in a single write. The other three are a dedicated IPI status/clear register, a dedicated timer status/clear register and a dedicated IPI request register. An external periodic tick raises the timer interrupt on every configured CPU at once.

Some writes have no effect on state. Posting an IPI that is already pending does nothing, and clearing one that is not pending does nothing. Each of these raises a one-cycle warning pulse. A write that carries no operation at all, or that names no CPU, raises a one-cycle error pulse. The `NUM_CPU` parameter limits every mask to the CPUs that are actually fitted, so bits for absent CPUs never change.

Top module: `ipi_timer_irq_ctl`

## Requirements
- R1: After reset, `ipiIrq`, `tmrIrq`, `warnPulse` and `errPulse` are all zero.
- R2: A write with `regSel`=0 (combined register) sets the IPI bit of each CPU whose bit is set in `wrData[15:12]`. `ipiIrq` shows the change after the clock edge that takes the write.
- R3: In a combined write, `wrData[11:8]` clears the IPI bits of the CPUs it names. The clear is applied after the request field of the same write, so a CPU that is both requested and cleared ends up with no pending IPI.
- R4: In a combined write, `wrData[7:4]` clears timer bits. Only bits that are currently set are affected. If `tickIn` is high in the same cycle, the tick takes priority and the timer bits end up set.
- R5: A combined write in which only bit 28 is set is accepted with no error and no state change. A combined write in which bit 28 and all of `[15:12]`, `[11:8]` and `[7:4]` are zero changes no state and raises `errPulse` for one cycle.
- R6: `warnPulse` goes high for one cycle when a write requests an IPI for a CPU whose IPI bit is already set. It also goes high when a write clears the IPI of a CPU that has none pending. The IPI vector stays as it was for those CPUs.
- R7: When `tickIn` is high, the timer bit of every configured CPU is set in the next cycle.
- R8: A read returns its data on `rdData` one cycle after `rdEn`. A read of the combined register returns `rdReqId` in bits [1:0], the timer vector in bits [7:4] and the IPI vector in bits [11:8], with all other bits zero. The values are those held before any write in the same cycle.
- R9: `regSel`=1 is the IPI status register, `regSel`=2 is the timer status register and `regSel`=3 is the IPI request register. A read of register 1 or 2 returns its vector in bits [3:0]. A write to register 1 or 2 clears the bits named in `wrData[3:0]`. A write to register 3 posts IPIs for `wrData[3:0]`. A read of register 3 returns zero.
- R10: A write to register 1, 2 or 3 with `wrData[3:0]` equal to zero changes no state and raises `errPulse` for one cycle.
- R11: Mask bits for CPUs numbered `NUM_CPU` or above have no effect and raise no warning. Outputs for those CPUs stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| regSel | input | 2 | Register select: 0 combined, 1 IPI status, 2 timer status, 3 IPI request |
| wrData | input | DATA_W | Write data |
| rdReqId | input | 2 | Number of the CPU issuing the read |
| tickIn | input | 1 | Periodic timer tick |
| rdData | output | DATA_W | Read data, valid one cycle after rdEn |
| ipiIrq | output | 4 | IPI level per CPU |
| tmrIrq | output | 4 | Timer interrupt level per CPU |
| warnPulse | output | 1 | One-cycle warning for a redundant post or clear |
| errPulse | output | 1 | One-cycle error for an empty or unsupported write |

## Verification
The bench builds the block with `NUM_CPU`=3 and the default 64-bit data width. This leaves CPU 3 absent, so masks that name only that CPU can be driven through all three dedicated registers. They must produce no state change, no warning and no error. With three CPUs fitted, a tick produces a timer vector of 0x7 rather than all ones, and that value tells the configured mask apart from the full 4-bit width.

// File: rtl/ipi_timer_pkg.sv
package ipi_timer_pkg;

  localparam int MAX_CPU = 4;

  // field positions inside the combined register
  localparam int MISC_REQ_LSB    = 12;
  localparam int MISC_IPICLR_LSB = 8;
  localparam int MISC_TMRCLR_LSB = 4;
  localparam int MISC_IGNORE_BIT = 28;
  localparam int RD_IPI_LSB      = 8;
  localparam int RD_TMR_LSB      = 4;

  typedef enum logic [1:0] {
    SEL_MISC     = 2'd0,
    SEL_IPI_STAT = 2'd1,
    SEL_TMR_STAT = 2'd2,
    SEL_IPI_REQ  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic [MAX_CPU-1:0] ipiSet;
    logic [MAX_CPU-1:0] ipiClr;
    logic [MAX_CPU-1:0] tmrClr;
    logic               tickSet;
    logic               rdEn;
    regSel_e            rdSel;
    logic [1:0]         rdReqId;
  } ctlStrobe_t;

  function automatic logic [MAX_CPU-1:0] cpuMask(input int n);
    logic [MAX_CPU-1:0] m;
    m = '0;
    for (int i = 0; i < MAX_CPU; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/ipi_timer_ctrl.sv
module ipi_timer_ctrl
  import ipi_timer_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int DATA_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdReqId,
  input  logic              tickIn,
  output ctlStrobe_t        strb,
  output logic              errPulse
);

  localparam logic [MAX_CPU-1:0] CFG = cpuMask(NUM_CPU);

  regSel_e            sel;
  logic [MAX_CPU-1:0] reqNib;
  logic [MAX_CPU-1:0] ipiClrNib;
  logic [MAX_CPU-1:0] tmrClrNib;
  logic [MAX_CPU-1:0] lowNib;
  logic               ignoreBit;
  logic               miscAny;
  logic               errNext;
  logic               unusedData;

  assign sel       = regSel_e'(regSel);
  assign reqNib    = wrData[MISC_REQ_LSB +: MAX_CPU];
  assign ipiClrNib = wrData[MISC_IPICLR_LSB +: MAX_CPU];
  assign tmrClrNib = wrData[MISC_TMRCLR_LSB +: MAX_CPU];
  assign lowNib    = wrData[MAX_CPU-1:0];
  assign ignoreBit = wrData[MISC_IGNORE_BIT];
  assign miscAny   = (|reqNib) | (|ipiClrNib) | (|tmrClrNib) | ignoreBit;

  // bits outside every decoded field
  assign unusedData = ^{wrData[DATA_W-1:MISC_IGNORE_BIT+1],
                        wrData[MISC_IGNORE_BIT-1:MISC_REQ_LSB+MAX_CPU]};

  always_comb begin
    strb         = '0;
    errNext      = 1'b0;
    strb.tickSet = tickIn;
    strb.rdEn    = rdEn;
    strb.rdSel   = sel;
    strb.rdReqId = rdReqId;
    if (wrEn) begin
      unique case (sel)
        SEL_MISC: begin
          if (miscAny) begin
            strb.ipiSet = reqNib & CFG;
            strb.ipiClr = ipiClrNib & CFG;
            strb.tmrClr = tmrClrNib & CFG;
          end else begin
            errNext = 1'b1;
          end
        end
        SEL_IPI_STAT: begin
          if (|lowNib) strb.ipiClr = lowNib & CFG;
          else         errNext = 1'b1;
        end
        SEL_TMR_STAT: begin
          if (|lowNib) strb.tmrClr = lowNib & CFG;
          else         errNext = 1'b1;
        end
        SEL_IPI_REQ: begin
          if (|lowNib) strb.ipiSet = lowNib & CFG;
          else         errNext = 1'b1;
        end
        default: errNext = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) errPulse <= 1'b0;
    else       errPulse <= errNext;
  end

endmodule

// File: rtl/ipi_timer_dpath.sv
module ipi_timer_dpath
  import ipi_timer_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int DATA_W  = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strb,
  output logic [MAX_CPU-1:0] ipiVec,
  output logic [MAX_CPU-1:0] tmrVec,
  output logic               warnPulse,
  output logic [DATA_W-1:0]  rdData
);

  logic [MAX_CPU-1:0] dupReq;
  logic [MAX_CPU-1:0] missClr;
  logic [DATA_W-1:0]  rdNext;

  for (genvar i = 0; i < MAX_CPU; i++) begin : g_cpu
    if (i < NUM_CPU) begin : g_live
      logic ipiQ;
      logic tmrQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          ipiQ <= 1'b0;
          tmrQ <= 1'b0;
        end else begin
          // request first, then clear; tick overrides a timer clear
          ipiQ <= (ipiQ | strb.ipiSet[i]) & ~strb.ipiClr[i];
          tmrQ <= (tmrQ & ~strb.tmrClr[i]) | strb.tickSet;
        end
      end
      assign ipiVec[i]  = ipiQ;
      assign tmrVec[i]  = tmrQ;
      assign dupReq[i]  = strb.ipiSet[i] & ipiQ;
      assign missClr[i] = strb.ipiClr[i] & ~(ipiQ | strb.ipiSet[i]);
    end else begin : g_absent
      assign ipiVec[i]  = 1'b0;
      assign tmrVec[i]  = 1'b0;
      assign dupReq[i]  = 1'b0;
      assign missClr[i] = 1'b0;
    end
  end

  always_comb begin
    rdNext = '0;
    unique case (strb.rdSel)
      SEL_MISC: begin
        rdNext[1:0]                   = strb.rdReqId;
        rdNext[RD_TMR_LSB +: MAX_CPU] = tmrVec;
        rdNext[RD_IPI_LSB +: MAX_CPU] = ipiVec;
      end
      SEL_IPI_STAT: rdNext[MAX_CPU-1:0] = ipiVec;
      SEL_TMR_STAT: rdNext[MAX_CPU-1:0] = tmrVec;
      SEL_IPI_REQ:  rdNext = '0;
      default:      rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      warnPulse <= 1'b0;
      rdData    <= '0;
    end else begin
      warnPulse <= (|dupReq) | (|missClr);
      if (strb.rdEn) rdData <= rdNext;
    end
  end

endmodule

// File: rtl/ipi_timer_irq_ctl.sv
module ipi_timer_irq_ctl
  import ipi_timer_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int DATA_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdReqId,
  input  logic              tickIn,
  output logic [DATA_W-1:0] rdData,
  output logic [3:0]        ipiIrq,
  output logic [3:0]        tmrIrq,
  output logic              warnPulse,
  output logic              errPulse
);

  ctlStrobe_t strb;

  ipi_timer_ctrl #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .regSel   (regSel),
    .wrData   (wrData),
    .rdReqId  (rdReqId),
    .tickIn   (tickIn),
    .strb     (strb),
    .errPulse (errPulse)
  );

  ipi_timer_dpath #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .ipiVec    (ipiIrq),
    .tmrVec    (tmrIrq),
    .warnPulse (warnPulse),
    .rdData    (rdData)
  );

endmodule

// File: rtl/ipi_timer_checker.sv
module ipi_timer_checker
  import ipi_timer_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [1:0] regSel,
  input logic       tickIn,
  input logic [3:0] ipiIrq,
  input logic [3:0] tmrIrq,
  input logic       warnPulse,
  input logic       errPulse
);

  localparam logic [3:0] CFG = cpuMask(NUM_CPU);

  logic ipiSetWr, ipiClrWr, tmrClrWr;
  assign ipiSetWr = wrEn && (regSel == SEL_MISC || regSel == SEL_IPI_REQ);
  assign ipiClrWr = wrEn && (regSel == SEL_MISC || regSel == SEL_IPI_STAT);
  assign tmrClrWr = wrEn && (regSel == SEL_MISC || regSel == SEL_TMR_STAT);

  a_r7_tick_sets_all: assert property (@(posedge clk) disable iff (!rstN)
    tickIn |=> ((tmrIrq & CFG) == CFG));

  a_r11_absent_cpus_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ((ipiIrq & ~CFG) == 4'b0) && ((tmrIrq & ~CFG) == 4'b0));

  a_r2_ipi_rise_needs_request: assert property (@(posedge clk) disable iff (!rstN)
    !ipiSetWr |=> ((ipiIrq & ~$past(ipiIrq)) == 4'b0));

  a_r3_ipi_fall_needs_clear: assert property (@(posedge clk) disable iff (!rstN)
    !ipiClrWr |=> ((~ipiIrq & $past(ipiIrq)) == 4'b0));

  a_r4_tmr_fall_needs_clear: assert property (@(posedge clk) disable iff (!rstN)
    !tmrClrWr |=> ((~tmrIrq & $past(tmrIrq)) == 4'b0));

  a_r10_err_only_after_write: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> !errPulse);

  a_r6_warn_only_after_ipi_write: assert property (@(posedge clk) disable iff (!rstN)
    !(ipiSetWr || ipiClrWr) |=> !warnPulse);

endmodule

bind ipi_timer_irq_ctl ipi_timer_checker #(.NUM_CPU(NUM_CPU)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .regSel    (regSel),
  .tickIn    (tickIn),
  .ipiIrq    (ipiIrq),
  .tmrIrq    (tmrIrq),
  .warnPulse (warnPulse),
  .errPulse  (errPulse)
);

// File: tb/ipi_timer_irq_ctl_test.sv
`timescale 1ns/1ps
module ipi_timer_irq_ctl_test;

  localparam int NC = 3;
  localparam int DW = 64;
  localparam logic [3:0] CFG = 4'b0111;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [1:0]    regSel = 2'd0;
  logic [DW-1:0] wrData = '0;
  logic [1:0]    rdReqId = 2'd0;
  logic          tickIn = 1'b0;
  logic [DW-1:0] rdData;
  logic [3:0]    ipiIrq, tmrIrq;
  logic          warnPulse, errPulse;

  always #5 clk = ~clk;

  ipi_timer_irq_ctl #(.NUM_CPU(NC), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regSel(regSel),
    .wrData(wrData), .rdReqId(rdReqId), .tickIn(tickIn), .rdData(rdData),
    .ipiIrq(ipiIrq), .tmrIrq(tmrIrq), .warnPulse(warnPulse), .errPulse(errPulse)
  );

  typedef struct {
    logic [3:0]    ipi;
    logic [3:0]    tmr;
    logic          warn;
    logic          err;
    bit            chkRd;
    logic [DW-1:0] rd;
    string         tag;
  } expItem_t;

  expItem_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [3:0] mIpi = 4'b0;
  logic [3:0] mTmr = 4'b0;

  task automatic cmp(input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor: one expected item per driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (q.size() != 0) begin
        expItem_t it;
        it = q.pop_front();
        cmp(it.tag, "ipiIrq", DW'(ipiIrq), DW'(it.ipi));
        cmp(it.tag, "tmrIrq", DW'(tmrIrq), DW'(it.tmr));
        cmp(it.tag, "warnPulse", DW'(warnPulse), DW'(it.warn));
        cmp(it.tag, "errPulse", DW'(errPulse), DW'(it.err));
        if (it.chkRd) cmp(it.tag, "rdData", rdData, it.rd);
      end
    end
  end

  // driver: applies one cycle of stimulus and predicts its result
  task automatic step(input bit wr, input bit rd, input logic [1:0] sel,
                      input logic [DW-1:0] d, input logic [1:0] id,
                      input bit tk, input string tag);
    expItem_t it;
    logic [3:0] req, clr, tclr, raw;
    @(negedge clk);
    wrEn = wr; rdEn = rd; regSel = sel; wrData = d; rdReqId = id; tickIn = tk;
    it.warn = 1'b0; it.err = 1'b0; it.chkRd = rd; it.tag = tag; it.rd = '0;
    if (rd) begin
      case (sel)
        2'd0: it.rd = DW'({mIpi, mTmr, 2'b00, id});
        2'd1: it.rd = DW'(mIpi);
        2'd2: it.rd = DW'(mTmr);
        default: it.rd = '0;
      endcase
    end
    raw = d[3:0];
    if (wr) begin
      case (sel)
        2'd0: begin
          if (d[28] || d[15:4] != 12'd0) begin
            req = d[15:12] & CFG; clr = d[11:8] & CFG; tclr = d[7:4] & CFG;
            it.warn = |(req & mIpi) || |(clr & ~(mIpi | req));
            mIpi = (mIpi | req) & ~clr;
            mTmr = mTmr & ~tclr;
          end else it.err = 1'b1;
        end
        2'd1: begin
          if (raw == 4'd0) it.err = 1'b1;
          else begin
            clr = raw & CFG;
            it.warn = |(clr & ~mIpi);
            mIpi = mIpi & ~clr;
          end
        end
        2'd2: begin
          if (raw == 4'd0) it.err = 1'b1;
          else mTmr = mTmr & ~(raw & CFG);
        end
        default: begin
          if (raw == 4'd0) it.err = 1'b1;
          else begin
            req = raw & CFG;
            it.warn = |(req & mIpi);
            mIpi = mIpi | req;
          end
        end
      endcase
    end
    if (tk) mTmr = mTmr | CFG;
    it.ipi = mIpi; it.tmr = mTmr;
    q.push_back(it);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 2'd0, '0, 2'd0, 1'b0, tag);
  endtask

  initial begin
    #200_0000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    idle("R1 reset state");
    step(1, 0, 2'd0, 64'h3000, 2'd0, 0, "R2 combined request cpu0,1");
    step(0, 1, 2'd0, '0, 2'd2, 0, "R8 combined read id2");
    step(1, 0, 2'd3, 64'h1, 2'd0, 0, "R6 duplicate request warns");
    step(1, 0, 2'd0, 64'h0400, 2'd0, 0, "R6 clear of idle cpu2 warns");
    step(1, 0, 2'd0, 64'h0, 2'd0, 1, "R10 empty combined write errors with tick");
    step(0, 1, 2'd1, '0, 2'd0, 0, "R9 read ipi status");
    step(0, 1, 2'd2, '0, 2'd0, 0, "R9 read timer status after R7 tick");
    step(1, 0, 2'd0, 64'h4100, 2'd0, 0, "R3 request cpu2 clear cpu0");
    step(1, 0, 2'd0, 64'h2200, 2'd0, 0, "R3 request and clear same cpu");
    step(1, 0, 2'd0, 64'h1000_0000, 2'd0, 0, "R5 bit28 accepted");
    step(1, 0, 2'd0, 64'h1_0000, 2'd0, 0, "R5 unsupported write errors");
    step(1, 0, 2'd0, 64'h0010, 2'd0, 0, "R4 timer clear cpu0");
    step(1, 0, 2'd0, 64'h0020, 2'd0, 1, "R4 tick beats timer clear");
    step(1, 0, 2'd2, 64'h0, 2'd0, 0, "R10 zero mask timer status");
    step(1, 0, 2'd1, 64'h8, 2'd0, 0, "R11 clear absent cpu3");
    step(1, 0, 2'd3, 64'h8, 2'd0, 0, "R11 request absent cpu3");
    step(1, 0, 2'd2, 64'h8, 2'd0, 0, "R11 timer clear absent cpu3");
    step(0, 1, 2'd0, '0, 2'd1, 0, "R8 combined read id1");
    step(1, 0, 2'd1, 64'h4, 2'd0, 0, "R9 ipi status clear");
    step(1, 0, 2'd2, 64'h7, 2'd0, 0, "R9 timer status clear");
    step(0, 1, 2'd3, '0, 2'd0, 0, "R9 request register reads zero");
    step(1, 0, 2'd3, 64'h0, 2'd0, 0, "R10 zero mask request");
    step(1, 1, 2'd3, 64'h5, 2'd3, 0, "R9 request post cpu0,2");
    step(1, 1, 2'd0, 64'h0100, 2'd3, 0, "R8 read sees pre-write state");
    idle("R1 pulses return low");
    idle("R7 idle hold");
    @(posedge clk); #4;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule